// File: doc/BRIEF.md
# Paged Program Counter Loader

This block holds the 13-bit instruction address of a small 8-bit processor and decides each cycle how that address moves. The address can step forward by one, take a new low byte written as a data register, take an 11-bit jump or call target, or take a full 13-bit return address from a call stack. A separate 5-bit page register supplies the upper address bits for the loads that cannot carry them.

The two partial loads draw on the page register in different ways. A low-byte write fills the whole upper five bits from it. A jump or call uses only its top two bits. A computed jump is a low-byte write whose data is the old low byte plus an offset. Any carry out of that sum is lost, so a table that runs past a 256-word boundary wraps inside the page that the register selects. Instruction decode and the stack storage sit outside this block.

Top module: `pc_loader`

## Requirements
- R1: While rstN is low, pcAddr, pcLow and pageQ are all zero. This holds even when load strobes are asserted.
- R2: With only incEn asserted, pcAddr advances by one at each clock edge. It wraps from 13'h1FFF to 13'h0000.
- R3: A low-byte write (lowWrEn) sets pcAddr to {pageQ[4:0], lowWrData[7:0]}.
- R4: After a low-byte write, the upper five address bits come from the page register and not from the previous address. No carry from the low byte ever reaches them.
- R5: A jump or call (jumpEn) sets pcAddr to {pageQ[4:3], jumpTarget[10:0]}. Page bits 2:0 have no effect.
- R6: A return (retEn) loads all 13 bits of pcAddr from retAddr and leaves pageQ unchanged.
- R7: pageQ takes pageWrData only at a clock edge where pageWrEn is high. A load in the same cycle uses the page value held before that edge.
- R8: When several strobes are asserted together, the priority is reset, then return, then jump, then low-byte write, then increment.
- R9: pcLow always equals pcAddr[7:0].
- R10: With no strobe asserted, pcAddr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Advance address by one |
| lowWrEn | input | 1 | Write low address byte as a data register |
| lowWrData | input | 8 | Data for the low-byte write |
| jumpEn | input | 1 | Jump or call strobe |
| jumpTarget | input | 11 | Immediate target of the jump or call |
| retEn | input | 1 | Load the full address from the stack |
| retAddr | input | 13 | Address popped from the stack |
| pageWrEn | input | 1 | Write the page register |
| pageWrData | input | 5 | Data for the page register |
| pcAddr | output | 13 | Current instruction address |
| pcLow | output | 8 | Readable low address byte |
| pageQ | output | 5 | Readable page register |

## Verification
The hardest case to reach is an address whose upper bits differ from the page register. Both the increment and the jump paths keep the two closely related, so that mismatch does not arise on its own. The bench reaches it through the return path, which can place the address anywhere, for example just below a page boundary or at 13'h1FFF. It then issues a low-byte write or an increment from that point. This is how the lost carry of a computed jump and the full-width wrap become visible at the ports. Same-cycle combinations of strobes and a page write cover the priority order and the rule that a load uses the old page value.

// File: rtl/pc_loader_pkg.sv
package pc_loader_pkg;

  // One-hot load selection handed from control to datapath
  typedef struct packed {
    logic doRet;
    logic doJump;
    logic doLow;
    logic doInc;
  } pcSelT;

endpackage

// File: rtl/pc_loader_ctrl.sv
module pc_loader_ctrl
  import pc_loader_pkg::*;
(
  input  logic  incEn,
  input  logic  lowWrEn,
  input  logic  jumpEn,
  input  logic  retEn,
  output pcSelT sel
);

  // Fixed priority: return > jump > low write > increment
  always_comb begin
    sel        = '0;
    sel.doRet  = retEn;
    sel.doJump = jumpEn  & ~retEn;
    sel.doLow  = lowWrEn & ~jumpEn & ~retEn;
    sel.doInc  = incEn   & ~lowWrEn & ~jumpEn & ~retEn;
  end

endmodule

// File: rtl/pc_loader_dp.sv
module pc_loader_dp
  import pc_loader_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 8,
  parameter int IMM_W  = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pcSelT                    sel,
  input  logic [LOW_W-1:0]         lowWrData,
  input  logic [IMM_W-1:0]         jumpTarget,
  input  logic [ADDR_W-1:0]        retAddr,
  input  logic                     pageWrEn,
  input  logic [ADDR_W-LOW_W-1:0]  pageWrData,
  output logic [ADDR_W-1:0]        pcAddr,
  output logic [ADDR_W-LOW_W-1:0]  pageQ
);

  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int JHI_W  = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] pcNext;
  logic [JHI_W-1:0]  jumpHi;

  assign jumpHi = pageQ[PAGE_W-1 -: JHI_W];

  always_comb begin
    pcNext = pcAddr;
    if (sel.doRet)       pcNext = retAddr;
    else if (sel.doJump) pcNext = {jumpHi, jumpTarget};
    else if (sel.doLow)  pcNext = {pageQ, lowWrData};
    else if (sel.doInc)  pcNext = pcAddr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcAddr <= '0;
    else       pcAddr <= pcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pageQ <= '0;
    else if (pageWrEn) pageQ <= pageWrData;
  end

endmodule

// File: rtl/pc_loader.sv
module pc_loader
  import pc_loader_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 8,
  parameter int IMM_W  = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    incEn,
  input  logic                    lowWrEn,
  input  logic [LOW_W-1:0]        lowWrData,
  input  logic                    jumpEn,
  input  logic [IMM_W-1:0]        jumpTarget,
  input  logic                    retEn,
  input  logic [ADDR_W-1:0]       retAddr,
  input  logic                    pageWrEn,
  input  logic [ADDR_W-LOW_W-1:0] pageWrData,
  output logic [ADDR_W-1:0]       pcAddr,
  output logic [LOW_W-1:0]        pcLow,
  output logic [ADDR_W-LOW_W-1:0] pageQ
);

  pcSelT sel;

  pc_loader_ctrl ctrl_i (
    .incEn   (incEn),
    .lowWrEn (lowWrEn),
    .jumpEn  (jumpEn),
    .retEn   (retEn),
    .sel     (sel)
  );

  pc_loader_dp #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .IMM_W(IMM_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sel        (sel),
    .lowWrData  (lowWrData),
    .jumpTarget (jumpTarget),
    .retAddr    (retAddr),
    .pageWrEn   (pageWrEn),
    .pageWrData (pageWrData),
    .pcAddr     (pcAddr),
    .pageQ      (pageQ)
  );

  assign pcLow = pcAddr[LOW_W-1:0];

endmodule

// File: rtl/pc_loader_chk.sv
module pc_loader_chk #(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 8,
  parameter int IMM_W  = 11
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    incEn,
  input logic                    lowWrEn,
  input logic [LOW_W-1:0]        lowWrData,
  input logic                    jumpEn,
  input logic [IMM_W-1:0]        jumpTarget,
  input logic                    retEn,
  input logic [ADDR_W-1:0]       retAddr,
  input logic                    pageWrEn,
  input logic [ADDR_W-LOW_W-1:0] pageWrData,
  input logic [ADDR_W-1:0]       pcAddr,
  input logic [LOW_W-1:0]        pcLow,
  input logic [ADDR_W-LOW_W-1:0] pageQ
);

  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int JHI_W  = ADDR_W - IMM_W;

  // R6 and R8: return wins over every other load
  assert_ret_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    retEn |=> pcAddr == $past(retAddr));

  // R5: jump takes the two top page bits
  assert_jump_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (jumpEn && !retEn) |=>
      pcAddr == {$past(pageQ[PAGE_W-1 -: JHI_W]), $past(jumpTarget)});

  // R3 and R4: low write takes the full page register
  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lowWrEn && !jumpEn && !retEn) |=>
      pcAddr == {$past(pageQ), $past(lowWrData)});

  // R2: increment covers all 13 bits
  assert_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !lowWrEn && !jumpEn && !retEn) |=>
      pcAddr == ADDR_W'($past(pcAddr) + 1));

  // R10: idle holds the address
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!incEn && !lowWrEn && !jumpEn && !retEn) |=> $stable(pcAddr));

  // R7: page register changes only on its own write
  assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pageWrEn |=> $stable(pageQ));

  // R9: readable low byte mirrors the address
  always_comb begin
    if (rstN) assert_low_mirror_R9: assert (pcLow == pcAddr[LOW_W-1:0]);
  end

endmodule

bind pc_loader pc_loader_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .IMM_W(IMM_W)) chk_i (
  .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrEn(lowWrEn), .lowWrData(lowWrData),
  .jumpEn(jumpEn), .jumpTarget(jumpTarget), .retEn(retEn), .retAddr(retAddr),
  .pageWrEn(pageWrEn), .pageWrData(pageWrData), .pcAddr(pcAddr), .pcLow(pcLow),
  .pageQ(pageQ)
);

// File: tb/pc_loader_tb_top.sv
module pc_loader_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        incEn, lowWrEn, jumpEn, retEn, pageWrEn;
  logic [7:0]  lowWrData;
  logic [10:0] jumpTarget;
  logic [12:0] retAddr;
  logic [4:0]  pageWrData;
  logic [12:0] pcAddr;
  logic [7:0]  pcLow;
  logic [4:0]  pageQ;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pc_loader dut_i (
    .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .jumpEn(jumpEn), .jumpTarget(jumpTarget), .retEn(retEn), .retAddr(retAddr),
    .pageWrEn(pageWrEn), .pageWrData(pageWrData), .pcAddr(pcAddr), .pcLow(pcLow),
    .pageQ(pageQ)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    incEn = 0; lowWrEn = 0; jumpEn = 0; retEn = 0; pageWrEn = 0;
    lowWrData = '0; jumpTarget = '0; retAddr = '0; pageWrData = '0;
  endtask

  // Apply current inputs at one clock edge, then release them
  task automatic step();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic setPage(input logic [4:0] v);
    pageWrEn = 1; pageWrData = v; step();
  endtask

  task automatic loadPc(input logic [12:0] v);
    retEn = 1; retAddr = v; step();
  endtask

  task automatic tReset();
    rstN = 0; incEn = 1; jumpEn = 1; jumpTarget = 11'h7FF;
    @(posedge clk); #1;
    check("R1 pcAddr", pcAddr, 0);
    check("R1 pageQ", pageQ, 0);
    check("R9 pcLow", pcLow, 0);
    clearIn(); rstN = 1; @(posedge clk); #1;
  endtask

  task automatic tIncrement();
    incEn = 1; step();
    incEn = 1; step();
    incEn = 1; step();
    check("R2 count", pcAddr, 13'h0003);
    step();
    check("R10 hold", pcAddr, 13'h0003);
    loadPc(13'h1FFF);
    check("R6 load", pcAddr, 13'h1FFF);
    incEn = 1; step();
    check("R2 wrap", pcAddr, 13'h0000);
  endtask

  task automatic tLowWrite();
    setPage(5'h15);
    check("R7 pageQ", pageQ, 5'h15);
    lowWrEn = 1; lowWrData = 8'hA7; step();
    check("R3 pcAddr", pcAddr, 13'h15A7);
    check("R9 pcLow", pcLow, 8'hA7);
  endtask

  task automatic tComputed();
    loadPc(13'h02FE);
    setPage(5'h02);
    lowWrEn = 1; lowWrData = 8'h03; step();  // 0xFE + 5 lost carry
    check("R4 wrap in page", pcAddr, 13'h0203);
    setPage(5'h1E);
    lowWrEn = 1; lowWrData = 8'h44; step();
    check("R4 page not pc", pcAddr, 13'h1E44);
  endtask

  task automatic tJump();
    setPage(5'h0D);
    jumpEn = 1; jumpTarget = 11'h7FF; step();
    check("R5 jump a", pcAddr, 13'h0FFF);
    setPage(5'h1B);
    jumpEn = 1; jumpTarget = 11'h123; step();
    check("R5 jump b", pcAddr, 13'h1923);
  endtask

  task automatic tReturn();
    setPage(5'h0A);
    loadPc(13'h1ABC);
    check("R6 retAddr", pcAddr, 13'h1ABC);
    check("R6 page kept", pageQ, 5'h0A);
  endtask

  task automatic tSameCycle();
    setPage(5'h04);
    pageWrEn = 1; pageWrData = 5'h1F; lowWrEn = 1; lowWrData = 8'h11; step();
    check("R7 old page used", pcAddr, 13'h0411);
    check("R7 new page", pageQ, 5'h1F);
  endtask

  task automatic tPriority();
    retEn = 1; retAddr = 13'h0055; jumpEn = 1; jumpTarget = 11'h3AA;
    lowWrEn = 1; lowWrData = 8'hEE; incEn = 1; step();
    check("R8 ret first", pcAddr, 13'h0055);
    jumpEn = 1; jumpTarget = 11'h001; lowWrEn = 1; lowWrData = 8'hEE; incEn = 1; step();
    check("R8 jump second", pcAddr, 13'h1801);
    lowWrEn = 1; lowWrData = 8'h40; incEn = 1; step();
    check("R8 low third", pcAddr, 13'h1F40);
  endtask

  initial begin
    clearIn();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1;
    tReset();
    tIncrement();
    tLowWrite();
    tComputed();
    tJump();
    tReturn();
    tSameCycle();
    tPriority();
    tReset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule